// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral Controller

This block decides when a half-duplex Ethernet transmitter may put a frame on a shared medium, and when it may try again. A bit-time strobe drives all of its timing. It watches carrier sense and collision detect and it drives the transmit enable. A client raises a frame request and holds it. The controller waits until the medium has been quiet for the inter-frame gap, then enables transmission. The client marks the end of the frame with a one-cycle end strobe.

If a collision arrives while the frame is going out, the controller selects the jam pattern for a fixed number of bit times and counts the collision. It then draws a random back-off of whole slot times, with a range that doubles at each collision up to a cap. After the back-off it waits for a quiet window on the medium, then a settle interval, and then retries. A collision that arrives after the first slot time of a frame is late: the frame is jammed and dropped without a retry. When the collision count goes past a programmable limit, the frame is abandoned. Each frame ends with exactly one of three status strobes: delivered, retries exhausted, or late collision.

Top module: `hdx_tx_defer`

## Requirements
- R1: A first attempt starts only after carrier sense has been low and the transmitter idle for at least 96 consecutive bit ticks. Transmit enable rises no more than 4 cycles after that count is reached.
- R2: While carrier sense is high and no frame is in progress, transmit enable stays low however long the request is held.
- R3: A collision while transmitting and before the late window raises jam select (1 = all-ones jam) on the next cycle. Jam select stays high together with transmit enable for 32 bit ticks, and both then drop.
- R4: After collision number n, the retry waits k slot times of 512 bit ticks, where k is a random integer in 0 to 2^min(n,10)−1. It then waits for carrier sense to be low for 60 bit ticks, then 36 more bit ticks, and then raises transmit enable. The total low time is therefore 96 ticks when k = 0 and 512·k + 36 ticks otherwise, each plus at most 4 cycles of state stepping.
- R5: When the collision count of one frame exceeds the retry limit, the block pulses the abort strobe after the jam instead of retrying. A frame therefore gets limit + 1 attempts.
- R6: A collision after 512 bit ticks of transmission is late. It is jammed, then the late strobe pulses and the frame is not retried. A collision at 500 ticks is still retried normally.
- R7: An end strobe while transmitting without a collision pulses the success strobe, and transmit enable drops in the same cycle. Every frame gets exactly one status strobe, and no strobe is high after reset.
- R8: The retry limit is a 4-bit register. It loads from the configuration input when the write enable is high and resets to 15. A limit of 0 abandons a frame on its first collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| tx_req | input | 1 | Frame pending; held until a status strobe |
| tx_end | input | 1 | One-cycle strobe: last bit of the frame sent |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| cfg_we | input | 1 | Load the retry limit |
| cfg_limit | input | 4 | New retry limit |
| tx_en | output | 1 | Transmit enable (frame or jam on the wire) |
| jam_sel | output | 1 | Select the all-ones jam pattern |
| done_ok | output | 1 | Frame delivered strobe |
| done_abort | output | 1 | Retry limit exhausted strobe |
| done_late | output | 1 | Late collision strobe |

## Verification
The assertions assume that the client raises the end strobe only while transmit enable is high, and that it drops the request within a few cycles of a status strobe. They also assume that bit ticks come every cycle, so that a gap measured in ticks also bounds the gap in cycles. The stimulus keeps the bit tick high on every cycle and pulses collision and end for exactly one cycle during transmission. It releases the request within three cycles of each status strobe. Because the back-off draw is random, the checks accept any permitted slot count rather than predicting a single value.

// File: rtl/hdx_defer_pkg.sv
package hdx_defer_pkg;
  localparam int unsigned IFG_TICKS    = 96;
  localparam int unsigned QUIET_TICKS  = 60;
  localparam int unsigned SETTLE_TICKS = 36;
  localparam int unsigned JAM_TICKS    = 32;
  localparam int unsigned SLOT_TICKS   = 512;
  localparam int unsigned BO_CAP       = 10;
  localparam int unsigned LIMIT_W      = 4;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_XMIT    = 3'd1,
    ST_JAM     = 3'd2,
    ST_BACKOFF = 3'd3,
    ST_QUIET   = 3'd4,
    ST_SETTLE  = 3'd5
  } hdx_state_e;
endpackage

// File: rtl/hdx_lfsr.sv
module hdx_lfsr #(
  parameter int unsigned W     = 16,
  parameter int unsigned OUT_W = 10,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] lfsr_q, lfsr_d;
  logic         fb;

  // Taps 16,14,13,11: maximal length for a 16-bit register
  always_comb begin
    fb     = lfsr_q[W-1] ^ lfsr_q[W-3] ^ lfsr_q[W-4] ^ lfsr_q[W-6];
    lfsr_d = {lfsr_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end

  assign rnd = lfsr_q[OUT_W-1:0];
endmodule

// File: rtl/hdx_quiet_cnt.sv
module hdx_quiet_cnt #(
  parameter int unsigned MAX = 96,
  localparam int unsigned QW = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          busy,
  input  logic          crs,
  output logic [QW-1:0] count
);
  logic [QW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (bit_tick) begin
      if (crs || busy)          cnt_d = '0;
      else if (cnt_q != QW'(MAX)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/hdx_backoff_calc.sv
module hdx_backoff_calc #(
  parameter int unsigned SLOT  = 512,
  parameter int unsigned CAP   = 10,
  parameter int unsigned NW    = 5,
  parameter int unsigned OUT_W = 19
) (
  input  logic [CAP-1:0]   rnd,
  input  logic [NW-1:0]    ncol,
  output logic [OUT_W-1:0] wait_ticks
);
  logic [CAP-1:0] mask;

  // Range doubles with each collision, truncated at CAP bits
  for (genvar i = 0; i < CAP; i++) begin : g_mask
    assign mask[i] = (32'(ncol) > i);
  end

  assign wait_ticks = OUT_W'(rnd & mask) * OUT_W'(SLOT);
endmodule

// File: rtl/hdx_tx_defer.sv
module hdx_tx_defer
  import hdx_defer_pkg::*;
#(
  parameter int unsigned IFG    = IFG_TICKS,
  parameter int unsigned QUIET  = QUIET_TICKS,
  parameter int unsigned SETTLE = SETTLE_TICKS,
  parameter int unsigned JAM    = JAM_TICKS,
  parameter int unsigned SLOT   = SLOT_TICKS,
  parameter int unsigned CAP    = BO_CAP,
  parameter int unsigned LW     = LIMIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          tx_req,
  input  logic          tx_end,
  input  logic          crs,
  input  logic          col,
  input  logic          cfg_we,
  input  logic [LW-1:0] cfg_limit,
  output logic          tx_en,
  output logic          jam_sel,
  output logic          done_ok,
  output logic          done_abort,
  output logic          done_late
);
  localparam int unsigned QW  = $clog2(IFG + 1);
  localparam int unsigned EW  = $clog2(SLOT + 1);
  localparam int unsigned NW  = LW + 1;
  localparam int unsigned BOW = $clog2(SLOT * (1 << CAP));
  localparam int unsigned TW  = (BOW > 8) ? BOW : 8;

  hdx_state_e    state_q, state_d;
  logic [TW-1:0] timer_q, timer_d;
  logic [EW-1:0] elapsed_q, elapsed_d;
  logic [NW-1:0] ncol_q, ncol_d;
  logic          late_q, late_d;
  logic [LW-1:0] limit_q, limit_d;
  logic          ok_q, ok_d, abort_q, abort_d, latep_q, latep_d;
  logic [QW-1:0] quiet_cnt;
  logic [CAP-1:0] rnd;
  logic [BOW-1:0] bo_ticks;

  hdx_lfsr #(.W(16), .OUT_W(CAP)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  hdx_quiet_cnt #(.MAX(IFG)) u_quiet (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .busy(tx_en), .crs(crs), .count(quiet_cnt)
  );

  hdx_backoff_calc #(.SLOT(SLOT), .CAP(CAP), .NW(NW), .OUT_W(BOW)) u_bo (
    .rnd(rnd), .ncol(ncol_q), .wait_ticks(bo_ticks)
  );

  always_comb begin
    state_d   = state_q;
    timer_d   = timer_q;
    elapsed_d = elapsed_q;
    ncol_d    = ncol_q;
    late_d    = late_q;
    limit_d   = cfg_we ? cfg_limit : limit_q;
    ok_d      = 1'b0;
    abort_d   = 1'b0;
    latep_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tx_req && quiet_cnt >= QW'(IFG)) begin
          state_d   = ST_XMIT;
          elapsed_d = '0;
          ncol_d    = '0;
          late_d    = 1'b0;
        end
      end
      ST_XMIT: begin
        if (bit_tick && elapsed_q != EW'(SLOT)) elapsed_d = elapsed_q + 1'b1;
        if (col) begin
          state_d = ST_JAM;
          timer_d = TW'(JAM - 1);
          if (elapsed_q == EW'(SLOT)) late_d = 1'b1;
          else                        ncol_d = ncol_q + 1'b1;
        end else if (tx_end) begin
          state_d = ST_IDLE;
          ok_d    = 1'b1;
        end
      end
      ST_JAM: begin
        if (timer_q == '0) begin
          if (late_q) begin
            state_d = ST_IDLE;
            latep_d = 1'b1;
          end else if (ncol_q > {1'b0, limit_q}) begin
            state_d = ST_IDLE;
            abort_d = 1'b1;
          end else begin
            state_d = ST_BACKOFF;
            timer_d = TW'(bo_ticks);
          end
        end else if (bit_tick) begin
          timer_d = timer_q - 1'b1;
        end
      end
      ST_BACKOFF: begin
        if (timer_q == '0)  state_d = ST_QUIET;
        else if (bit_tick)  timer_d = timer_q - 1'b1;
      end
      ST_QUIET: begin
        if (quiet_cnt >= QW'(QUIET)) begin
          state_d = ST_SETTLE;
          timer_d = TW'(SETTLE);
        end
      end
      ST_SETTLE: begin
        if (timer_q == '0) begin
          state_d   = ST_XMIT;
          elapsed_d = '0;
        end else if (bit_tick) begin
          timer_d = timer_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      timer_q   <= '0;
      elapsed_q <= '0;
      ncol_q    <= '0;
      late_q    <= 1'b0;
      limit_q   <= '1;
      ok_q      <= 1'b0;
      abort_q   <= 1'b0;
      latep_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      timer_q   <= timer_d;
      elapsed_q <= elapsed_d;
      ncol_q    <= ncol_d;
      late_q    <= late_d;
      limit_q   <= limit_d;
      ok_q      <= ok_d;
      abort_q   <= abort_d;
      latep_q   <= latep_d;
    end
  end

  assign tx_en      = (state_q == ST_XMIT) || (state_q == ST_JAM);
  assign jam_sel    = (state_q == ST_JAM);
  assign done_ok    = ok_q;
  assign done_abort = abort_q;
  assign done_late  = latep_q;
endmodule

// File: rtl/hdx_tx_defer_chk.sv
module hdx_tx_defer_chk
  import hdx_defer_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       crs,
  input logic       col,
  input logic       tx_en,
  input logic       jam_sel,
  input logic       done_ok,
  input logic       done_abort,
  input logic       done_late,
  input hdx_state_e state
);
  localparam int unsigned MIN_GAP = QUIET_TICKS + SETTLE_TICKS;

  logic [8:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          gap_q <= '0;
    else if (tx_en)                      gap_q <= '0;
    else if (bit_tick && gap_q != 9'h1FF) gap_q <= gap_q + 1'b1;
  end

  assert_min_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (32'(gap_q) >= MIN_GAP));

  assert_no_start_on_carrier_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (crs && state == ST_IDLE) |=> !tx_en);

  assert_jam_within_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    jam_sel |-> tx_en);

  assert_col_to_jam_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !jam_sel && col) |=> jam_sel);

  assert_fail_after_jam_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_late || done_abort) |-> (!tx_en && $past(jam_sel)));

  assert_single_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_ok, done_abort, done_late}));

  assert_ok_ends_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> (!tx_en && $past(tx_en) && !$past(jam_sel)));
endmodule

bind hdx_tx_defer hdx_tx_defer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .crs(crs), .col(col),
  .tx_en(tx_en), .jam_sel(jam_sel), .done_ok(done_ok),
  .done_abort(done_abort), .done_late(done_late), .state(state_q)
);

// File: tb/hdx_tx_defer_tb.sv
module hdx_tx_defer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ST_OK = 1, ST_ABORT = 2, ST_LATE = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 1'b1, tx_req = 1'b0, tx_end = 1'b0, crs = 1'b0, col = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_limit = 4'd0;
  logic tx_en, jam_sel, done_ok, done_abort, done_late;

  int checks = 0, fails = 0;
  int exp_q[$];
  int low_run = 0, last_gap = 0, jam_run = 0, last_jam = 0, rises = 0, ndone = 0;
  bit prev_en = 1'b0, finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdx_tx_defer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_req(tx_req),
    .tx_end(tx_end), .crs(crs), .col(col), .cfg_we(cfg_we),
    .cfg_limit(cfg_limit), .tx_en(tx_en), .jam_sel(jam_sel),
    .done_ok(done_ok), .done_abort(done_abort), .done_late(done_late)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: timing of enable and jam, scoreboard for status strobes
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_en) begin
        if (!prev_en) begin last_gap = low_run; rises++; end
        low_run = 0;
      end else low_run++;
      prev_en = tx_en;
      if (jam_sel) jam_run++;
      else if (jam_run > 0) begin last_jam = jam_run; jam_run = 0; end
      if (done_ok || done_abort || done_late) begin
        automatic int code = done_ok ? ST_OK : (done_abort ? ST_ABORT : ST_LATE);
        ndone++;
        if (exp_q.size() == 0) check(0, "R7 unexpected status", code, 0);
        else begin
          automatic int e = exp_q.pop_front();
          check(code == e, "R7 status code", code, e);
        end
      end
    end
  end

  function automatic bit gap_ok(input int len, input int n);
    int e = (n > 10) ? 10 : n;
    for (int k = 0; k < (1 << e); k++) begin
      int base = (k == 0) ? 96 : 512 * k + 36;
      if (len >= base && len <= base + 4) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise(input int limit);
    int r0 = rises;
    for (int i = 0; i < limit && rises == r0; i++) @(negedge clk);
  endtask

  task automatic wait_status(input int limit);
    int d0 = ndone;
    for (int i = 0; i < limit && ndone == d0; i++) @(negedge clk);
  endtask

  task automatic pulse_col();
    col = 1'b1; @(negedge clk); col = 1'b0;
  endtask

  task automatic pulse_end();
    tx_end = 1'b1; @(negedge clk); tx_end = 1'b0;
  endtask

  task automatic set_limit(input int v);
    cfg_limit = 4'(v); cfg_we = 1'b1; @(negedge clk); cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int r0, c;
    cycles(4);
    rst_n = 1'b1;
    cycles(1);
    check({tx_en, jam_sel, done_ok, done_abort, done_late} == 5'b0, "R7 reset outputs",
          int'({tx_en, jam_sel, done_ok, done_abort, done_late}), 0);

    // R2: carrier held, request pending
    crs = 1'b1; tx_req = 1'b1;
    cycles(300);
    check(rises == 0, "R2 no start under carrier", rises, 0);
    // R1: count cycles from carrier drop to enable
    crs = 1'b0; c = 0;
    while (!tx_en && c < 1000) begin @(negedge clk); c++; end
    check(c >= 96 && c <= 100, "R1 gap before first attempt", c, 97);
    cycles(40);
    exp_q.push_back(ST_OK);
    pulse_end();
    check(tx_en == 1'b0, "R7 enable drops on end", tx_en, 0);
    cycles(2); tx_req = 1'b0;

    // R3/R4: early collision then retry, then success
    tx_req = 1'b1;
    wait_rise(2000);
    cycles(100);
    pulse_col();
    check(jam_sel == 1'b1 && tx_en == 1'b1, "R3 jam after collision", jam_sel, 1);
    wait_rise(3000);
    check(last_jam >= 32 && last_jam <= 33, "R3 jam length", last_jam, 32);
    check(gap_ok(last_gap, 1), "R4 retry spacing n=1", last_gap, 98);
    cycles(30);
    exp_q.push_back(ST_OK);
    pulse_end();
    cycles(2); tx_req = 1'b0;

    // R5: limit 2, every attempt collides
    set_limit(2);
    r0 = rises;
    exp_q.push_back(ST_ABORT);
    tx_req = 1'b1;
    for (int a = 0; a < 3; a++) begin
      wait_rise(5000);
      if (a > 0) check(gap_ok(last_gap, a), "R4 retry spacing", last_gap, 98);
      cycles(20);
      pulse_col();
    end
    wait_status(5000);
    cycles(2); tx_req = 1'b0;
    check(rises - r0 == 3, "R5 attempts with limit 2", rises - r0, 3);
    cycles(200);
    check(rises - r0 == 3, "R5 no retry after abort", rises - r0, 3);

    // R8: limit 0 abandons on first collision
    set_limit(0);
    r0 = rises;
    exp_q.push_back(ST_ABORT);
    tx_req = 1'b1;
    wait_rise(2000);
    cycles(20);
    pulse_col();
    wait_status(200);
    cycles(2); tx_req = 1'b0;
    cycles(1000);
    check(rises - r0 == 1, "R8 limit zero single attempt", rises - r0, 1);

    // R6: collision just inside the window is retried
    set_limit(15);
    tx_req = 1'b1;
    wait_rise(2000);
    r0 = rises;
    cycles(500);
    pulse_col();
    wait_rise(3000);
    check(rises - r0 == 1, "R6 collision at 500 retried", rises - r0, 1);
    cycles(10);
    exp_q.push_back(ST_OK);
    pulse_end();
    cycles(2); tx_req = 1'b0;

    // R6: late collision, no retry
    tx_req = 1'b1;
    wait_rise(2000);
    cycles(600);
    exp_q.push_back(ST_LATE);
    pulse_col();
    wait_status(200);
    cycles(2); tx_req = 1'b0;
    r0 = rises;
    cycles(1500);
    check(rises == r0 && !tx_en, "R6 no retry after late collision", rises - r0, 0);
    check(last_jam >= 32 && last_jam <= 33, "R3 late jam length", last_jam, 32);

    check(exp_q.size() == 0, "R7 all statuses seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule